// File: doc/BRIEF.md
# Dual-Issue Pairing and Address-Stall Arbiter

This block sits at the head of an in-order instruction buffer that feeds two integer pipelines, one primary and one secondary. Each cycle it receives the two oldest pre-decoded instruction descriptors. It decides whether the oldest one goes to the primary pipeline and whether the next one may go to the secondary pipeline in the same cycle. An instruction that cannot pair stays in the buffer and becomes the oldest entry on the following cycle, so it then issues to the primary pipeline.

The block also keeps a record of the group it dispatched on the previous decision. It compares that record with the address operands (base and index registers) of the instructions now at the head. If a result is needed for address generation before it is ready, the block inserts a counted stall. A few simple writes deliver their result early, and the scale and size of an index operand set the penalty.

The decision is registered: the head presented in one cycle is judged at the next rising edge, and the result appears on the outputs after that edge. A flush input discards any pending stall and any pending decision.

Top module: `dual_issue_arbiter`

## Requirements
- R1: A descriptor is 37 bits. Bits [3:0] dst register, bit 4 dst valid. Bits [8:5] source A, bit 9 valid. Bits [13:10] source B, bit 14 valid. Bits [18:15] base register, bit 19 valid. Bits [23:20] index register, bit 24 valid, bits [26:25] index scale (0 = x1, 1 = x2, 2 = x4, 3 = x8), bit 27 index is long. Bits [31:28] auto-update register (postincrement or predecrement), bit 32 valid. Bit 33 early-result write, bit 34 dst loaded from memory, bit 35 floating-point, bit 36 primary-only. Register ids 0-7 are data registers and 8-15 are address registers.
- R2: Out of reset all outputs are zero. The decision for the head presented in a cycle appears after the next rising edge: `pri_issue` means slot 0 went to the primary pipeline, `pair_en` means slot 1 went to the secondary pipeline, and `pop_cnt` gives the number of entries consumed. With no valid slot 0, nothing is dispatched.
- R3: Slot 1 is dispatched only in the same decision that dispatches slot 0. Two independent valid integer instructions pair.
- R4: No pairing when slot 0 writes a register (dst or auto-update) that slot 1 reads (source A, source B, base or index), or one that slot 1 also writes.
- R5: A floating-point instruction in slot 1 never pairs. One in slot 0 may pair with an integer slot 1.
- R6: A primary-only instruction in either slot forces single issue.
- R7: A register field whose valid bit is clear never creates a dependency or a stall.
- R8: A register written by an early-result instruction, or by auto-update, and used next as a base register, or as a long index scaled x1 or x4, costs no stall.
- R9: A register like those in R8, used next as an index scaled x2 or x8, or as a word index, costs 3 stall cycles.
- R10: A register loaded from memory (not early) and used next in an address calculation costs 1 stall cycle.
- R11: Any other register write used next in an address costs 3 stall cycles. Use as a data source costs none.
- R12: A stall of N cycles shows `stall_cnt` = N, N-1, ..., 1 on N consecutive cycles with no dispatch, then slot 0 issues. Slot 1 does not pair if it would itself stall against the previous group. "Next" means the group dispatched in the immediately preceding decision.
- R13: A `flush` cycle clears the outputs, the pending stall and the producer record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Discard pending stall and decision |
| hd0_vld | input | 1 | Slot 0 (oldest) holds an instruction |
| hd0_desc | input | 37 | Slot 0 descriptor |
| hd1_vld | input | 1 | Slot 1 holds an instruction |
| hd1_desc | input | 37 | Slot 1 descriptor |
| pri_issue | output | 1 | Slot 0 dispatched to primary pipeline |
| pair_en | output | 1 | Slot 1 dispatched to secondary pipeline |
| pop_cnt | output | 2 | Buffer entries consumed |
| stall_cnt | output | 2 | Remaining stall cycles |

## Verification
Some rules are checked by the assertions on every cycle:
- Slot 1 never dispatches alone.
- No pairing with a read-after-write hazard, a floating-point slot 1 or a primary-only slot.
- The countdown drops by one with no dispatch.
- A flush leaves a cleared state.

Other behaviour only the bench scenarios can show, through its reference model:
- The stall penalties for each producer kind and each index form.
- Early results and auto-update writes costing nothing.
- Stall interaction across paired groups.
- Invalid fields having no effect.
- Randomised descriptor streams.

// File: rtl/dis_pkg.sv
package dis_pkg;

  localparam int REG_W = 4;

  typedef logic [REG_W-1:0] reg_id_t;

  // Field order places dst at the least significant bits.
  typedef struct packed {
    logic       pri_only;
    logic       fp;
    logic       mem_ld;
    logic       early;
    logic       upd_v;
    reg_id_t    upd;
    logic       idx_long;
    logic [1:0] idx_scale;
    logic       idx_v;
    reg_id_t    idx;
    logic       base_v;
    reg_id_t    base;
    logic       srcb_v;
    reg_id_t    srcb;
    logic       srca_v;
    reg_id_t    srca;
    logic       dst_v;
    reg_id_t    dst;
  } idesc_t;

  localparam int DESC_W = $bits(idesc_t);

  // True when the instruction writes register r (destination or auto-update).
  function automatic logic writes_reg(idesc_t p, reg_id_t r);
    return (p.dst_v && (p.dst == r)) || (p.upd_v && (p.upd == r));
  endfunction

  // Long index with a scale of x1 or x4 takes the fast address path.
  function automatic logic idx_is_fast(idesc_t c);
    return c.idx_long && ((c.idx_scale == 2'd0) || (c.idx_scale == 2'd2));
  endfunction

  // Penalty for one address use of a freshly written register.
  function automatic int addr_use_cost(logic quick, logic mload, logic as_idx,
                                       logic fast_idx, int slow, int ldc, int dflt);
    if (quick)      return (as_idx && !fast_idx) ? slow : 0;
    else if (mload) return ldc;
    else            return dflt;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pair_dep_unit.sv
module pair_dep_unit
  import dis_pkg::*;
(
  input  idesc_t older,
  input  idesc_t younger,
  output logic   raw_hit,
  output logic   waw_hit,
  output logic   cls_block
);
  localparam int NRD = 4;
  localparam int NWR = 2;

  reg_id_t        rd_id [NRD];
  logic           rd_v  [NRD];
  reg_id_t        wr_id [NWR];
  logic           wr_v  [NWR];
  logic [NRD-1:0] rd_hit;
  logic [NWR-1:0] wr_hit;

  always_comb begin
    rd_id[0] = younger.srca;  rd_v[0] = younger.srca_v;
    rd_id[1] = younger.srcb;  rd_v[1] = younger.srcb_v;
    rd_id[2] = younger.base;  rd_v[2] = younger.base_v;
    rd_id[3] = younger.idx;   rd_v[3] = younger.idx_v;
    wr_id[0] = younger.dst;   wr_v[0] = younger.dst_v;
    wr_id[1] = younger.upd;   wr_v[1] = younger.upd_v;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_hit[g] = rd_v[g] && writes_reg(older, rd_id[g]);
  end

  for (genvar g = 0; g < NWR; g++) begin : g_wr
    assign wr_hit[g] = wr_v[g] && writes_reg(older, wr_id[g]);
  end

  assign raw_hit   = |rd_hit;
  assign waw_hit   = |wr_hit;
  assign cls_block = younger.fp || younger.pri_only || older.pri_only;

  // R7
  always_comb begin
    no_write_no_hit_chk: assert ((older.dst_v || older.upd_v) || (!raw_hit && !waw_hit));
  end

endmodule

// File: rtl/agen_stall_calc.sv
module agen_stall_calc
  import dis_pkg::*;
#(
  parameter int SLOW_IDX_STALL  = 3,
  parameter int AREG_LOAD_STALL = 1,
  parameter int GEN_USE_STALL   = 3,
  parameter int STALL_W         = 2
) (
  input  idesc_t             prod,
  input  logic               prod_v,
  input  idesc_t             cons,
  input  logic               cons_v,
  output logic [STALL_W-1:0] cost
);
  logic act;
  logic dst_base, dst_idx, upd_base, upd_idx;
  logic fast;
  logic dst_quick, dst_mload;
  int   c_db, c_di, c_ub, c_ui, worst;

  assign act       = prod_v && cons_v;
  assign fast      = idx_is_fast(cons);
  assign dst_quick = prod.early;
  assign dst_mload = prod.mem_ld;

  assign dst_base = act && prod.dst_v && cons.base_v && (prod.dst == cons.base);
  assign dst_idx  = act && prod.dst_v && cons.idx_v  && (prod.dst == cons.idx);
  assign upd_base = act && prod.upd_v && cons.base_v && (prod.upd == cons.base);
  assign upd_idx  = act && prod.upd_v && cons.idx_v  && (prod.upd == cons.idx);

  always_comb begin
    c_db  = dst_base ? addr_use_cost(dst_quick, dst_mload, 1'b0, fast,
                                     SLOW_IDX_STALL, AREG_LOAD_STALL, GEN_USE_STALL) : 0;
    c_di  = dst_idx  ? addr_use_cost(dst_quick, dst_mload, 1'b1, fast,
                                     SLOW_IDX_STALL, AREG_LOAD_STALL, GEN_USE_STALL) : 0;
    c_ub  = upd_base ? addr_use_cost(1'b1, 1'b0, 1'b0, fast,
                                     SLOW_IDX_STALL, AREG_LOAD_STALL, GEN_USE_STALL) : 0;
    c_ui  = upd_idx  ? addr_use_cost(1'b1, 1'b0, 1'b1, fast,
                                     SLOW_IDX_STALL, AREG_LOAD_STALL, GEN_USE_STALL) : 0;
    worst = imax(imax(c_db, c_di), imax(c_ub, c_ui));
    cost  = STALL_W'(worst);
  end

endmodule

// File: rtl/issue_sel_ctrl.sv
module issue_sel_ctrl
  import dis_pkg::*;
#(
  parameter int STALL_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               hd0_v,
  input  logic               hd1_v,
  input  idesc_t             hd0,
  input  idesc_t             hd1,
  input  logic [STALL_W-1:0] s0,
  input  logic [STALL_W-1:0] s1,
  input  logic               raw_hit,
  input  logic               waw_hit,
  input  logic               cls_block,
  output logic               pri_q,
  output logic               sec_q,
  output logic [STALL_W-1:0] stall_q,
  output logic [1:0]         prod_v,
  output idesc_t             prod0,
  output idesc_t             prod1
);
  localparam logic [STALL_W-1:0] ONE = STALL_W'(1);

  logic eval_en, stall_go, pri_go, pair_go, counting;

  assign counting = stall_q > ONE;
  assign eval_en  = !flush && !counting;
  assign stall_go = eval_en && hd0_v && (s0 != '0);
  assign pri_go   = eval_en && hd0_v && (s0 == '0);
  assign pair_go  = pri_go && hd1_v && !raw_hit && !waw_hit && !cls_block && (s1 == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_q   <= 1'b0;
      sec_q   <= 1'b0;
      stall_q <= '0;
      prod_v  <= '0;
      prod0   <= '0;
      prod1   <= '0;
    end else if (flush) begin
      pri_q   <= 1'b0;
      sec_q   <= 1'b0;
      stall_q <= '0;
      prod_v  <= '0;
    end else if (counting) begin
      pri_q   <= 1'b0;
      sec_q   <= 1'b0;
      stall_q <= stall_q - ONE;
    end else if (stall_go) begin
      pri_q   <= 1'b0;
      sec_q   <= 1'b0;
      stall_q <= s0;
      prod_v  <= '0;
    end else if (pri_go) begin
      pri_q   <= 1'b1;
      sec_q   <= pair_go;
      stall_q <= '0;
      prod_v  <= {pair_go, 1'b1};
      prod0   <= hd0;
      prod1   <= hd1;
    end else begin
      pri_q   <= 1'b0;
      sec_q   <= 1'b0;
      stall_q <= '0;
      prod_v  <= '0;
    end
  end

  // R3
  sec_with_pri_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_q |-> pri_q);

  // R4
  raw_no_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_hit || waw_hit) |-> !pair_go);

  // R5
  fp_not_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_go |-> !hd1.fp);

  // R6
  pri_only_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_go |-> (!hd0.pri_only && !hd1.pri_only));

  // R12
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (counting && !flush) |=> (!pri_q && !sec_q));

  // R12
  stall_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (counting && !flush) |=> (stall_q == $past(stall_q) - ONE));

  // R13
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (stall_q == '0 && !pri_q && !sec_q && prod_v == '0));

endmodule

// File: rtl/dual_issue_arbiter.sv
module dual_issue_arbiter
  import dis_pkg::*;
#(
  parameter int SLOW_IDX_STALL  = 3,
  parameter int AREG_LOAD_STALL = 1,
  parameter int GEN_USE_STALL   = 3,
  localparam int MAX_STALL      = imax(imax(SLOW_IDX_STALL, AREG_LOAD_STALL), GEN_USE_STALL),
  localparam int STALL_W        = $clog2(MAX_STALL + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               hd0_vld,
  input  logic [DESC_W-1:0]  hd0_desc,
  input  logic               hd1_vld,
  input  logic [DESC_W-1:0]  hd1_desc,
  output logic               pri_issue,
  output logic               pair_en,
  output logic [1:0]         pop_cnt,
  output logic [STALL_W-1:0] stall_cnt
);
  localparam int NSLOT = 2;

  idesc_t             slot_d [NSLOT];
  logic               slot_v [NSLOT];
  idesc_t             prod_d [NSLOT];
  logic [NSLOT-1:0]   prod_v;
  logic [STALL_W-1:0] cost   [NSLOT][NSLOT];
  logic [STALL_W-1:0] slot_stall [NSLOT];
  logic               raw_hit, waw_hit, cls_block;
  idesc_t             p0, p1;

  assign slot_d[0] = idesc_t'(hd0_desc);
  assign slot_d[1] = idesc_t'(hd1_desc);
  assign slot_v[0] = hd0_vld;
  assign slot_v[1] = hd1_vld;
  assign prod_d[0] = p0;
  assign prod_d[1] = p1;

  for (genvar gc = 0; gc < NSLOT; gc++) begin : g_cons
    for (genvar gp = 0; gp < NSLOT; gp++) begin : g_prod
      agen_stall_calc #(
        .SLOW_IDX_STALL (SLOW_IDX_STALL),
        .AREG_LOAD_STALL(AREG_LOAD_STALL),
        .GEN_USE_STALL  (GEN_USE_STALL),
        .STALL_W        (STALL_W)
      ) u_cost (
        .prod  (prod_d[gp]),
        .prod_v(prod_v[gp]),
        .cons  (slot_d[gc]),
        .cons_v(slot_v[gc]),
        .cost  (cost[gc][gp])
      );
    end
    assign slot_stall[gc] = (cost[gc][0] > cost[gc][1]) ? cost[gc][0] : cost[gc][1];
  end

  pair_dep_unit u_dep (
    .older    (slot_d[0]),
    .younger  (slot_d[1]),
    .raw_hit  (raw_hit),
    .waw_hit  (waw_hit),
    .cls_block(cls_block)
  );

  issue_sel_ctrl #(.STALL_W(STALL_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .hd0_v    (hd0_vld),
    .hd1_v    (hd1_vld),
    .hd0      (slot_d[0]),
    .hd1      (slot_d[1]),
    .s0       (slot_stall[0]),
    .s1       (slot_stall[1]),
    .raw_hit  (raw_hit),
    .waw_hit  (waw_hit),
    .cls_block(cls_block),
    .pri_q    (pri_issue),
    .sec_q    (pair_en),
    .stall_q  (stall_cnt),
    .prod_v   (prod_v),
    .prod0    (p0),
    .prod1    (p1)
  );

  assign pop_cnt = {1'b0, pri_issue} + {1'b0, pair_en};

  // R12
  no_dispatch_in_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_cnt != '0) |-> (pop_cnt == 2'd0));

endmodule

// File: tb/sim_dual_issue_arbiter.sv
module sim_dual_issue_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 37;
  localparam logic [DW-1:0] K_EARLY = 37'h0200000000;
  localparam logic [DW-1:0] K_MEMLD = 37'h0400000000;
  localparam logic [DW-1:0] K_FP    = 37'h0800000000;
  localparam logic [DW-1:0] K_PONLY = 37'h1000000000;

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0, v0 = 1'b0, v1 = 1'b0;
  logic [DW-1:0] d0 = '0, d1 = '0;
  logic pri_issue, pair_en;
  logic [1:0] pop_cnt, stall_cnt;

  dual_issue_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .hd0_vld(v0), .hd0_desc(d0), .hd1_vld(v1), .hd1_desc(d1),
    .pri_issue(pri_issue), .pair_en(pair_en), .pop_cnt(pop_cnt), .stall_cnt(stall_cnt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nvec = 0, nbad = 0;
  logic [DW-1:0] prog[$];
  int mst = 0;
  logic [DW-1:0] mp [2];
  bit mpv [2];
  bit exp_pri = 0, exp_pair = 0;
  int exp_pop = 0, exp_st = 0;
  string cur_tag = "R2", prev_tag = "R2";

  // Descriptor builders (layout of R1)
  function automatic logic [DW-1:0] f_dst(int r);
    logic [DW-1:0] x = '0; x[3:0] = 4'(r); x[4] = 1'b1; return x;
  endfunction
  function automatic logic [DW-1:0] f_srca(int r);
    logic [DW-1:0] x = '0; x[8:5] = 4'(r); x[9] = 1'b1; return x;
  endfunction
  function automatic logic [DW-1:0] f_base(int r);
    logic [DW-1:0] x = '0; x[18:15] = 4'(r); x[19] = 1'b1; return x;
  endfunction
  function automatic logic [DW-1:0] f_idx(int r, int sc, int lng);
    logic [DW-1:0] x = '0; x[23:20] = 4'(r); x[24] = 1'b1;
    x[26:25] = 2'(sc); x[27] = (lng != 0); return x;
  endfunction
  function automatic logic [DW-1:0] f_upd(int r);
    logic [DW-1:0] x = '0; x[31:28] = 4'(r); x[32] = 1'b1; return x;
  endfunction

  function automatic int rr();
    return int'($urandom % 2) * 8 + int'($urandom % 2);
  endfunction

  function automatic logic [DW-1:0] rand_desc();
    logic [DW-1:0] x = '0;
    if ($urandom % 4 != 0) x |= f_dst(rr());
    if ($urandom % 2 == 0) x |= f_srca(rr());
    if ($urandom % 3 == 0) x[13:10] = 4'(rr());
    if ($urandom % 3 == 0) x[14] = 1'b1;
    if ($urandom % 2 == 0) x |= f_base(rr());
    if ($urandom % 3 == 0) x |= f_idx(rr(), int'($urandom % 4), int'($urandom % 2));
    if ($urandom % 5 == 0) x |= f_upd(rr());
    if ($urandom % 4 == 0) x |= K_EARLY;
    if ($urandom % 4 == 0) x |= K_MEMLD;
    if ($urandom % 8 == 0) x |= K_FP;
    if ($urandom % 8 == 0) x |= K_PONLY;
    return x;
  endfunction

  // Penalty of consumer c against one earlier producer p (R8-R11)
  function automatic int use_penalty(logic [DW-1:0] p, logic [DW-1:0] c);
    int worst = 0;
    for (int w = 0; w < 2; w++) begin
      bit wv    = (w == 0) ? p[4] : p[32];
      int wr    = (w == 0) ? int'(p[3:0]) : int'(p[31:28]);
      bit quick = (w == 1) || p[33];
      bit mload = (w == 0) && p[34];
      bit slow  = !(c[27] && (c[26:25] == 2'd0 || c[26:25] == 2'd2));
      int pen;
      if (wv && c[19] && int'(c[18:15]) == wr) begin
        pen = quick ? 0 : (mload ? 1 : 3);
        if (pen > worst) worst = pen;
      end
      if (wv && c[24] && int'(c[23:20]) == wr) begin
        pen = quick ? (slow ? 3 : 0) : (mload ? 1 : 3);
        if (pen > worst) worst = pen;
      end
    end
    return worst;
  endfunction

  function automatic int head_pen(logic [DW-1:0] c);
    int s = 0;
    for (int k = 0; k < 2; k++)
      if (mpv[k] && use_penalty(mp[k], c) > s) s = use_penalty(mp[k], c);
    return s;
  endfunction

  // Older a against younger b (R4)
  function automatic bit conflicts(logic [DW-1:0] a, logic [DW-1:0] b);
    bit hit = 0;
    for (int w = 0; w < 2; w++) begin
      bit wv = (w == 0) ? a[4] : a[32];
      logic [3:0] wr = (w == 0) ? a[3:0] : a[31:28];
      if (wv) begin
        if (b[9]  && b[8:5]   == wr) hit = 1;
        if (b[14] && b[13:10] == wr) hit = 1;
        if (b[19] && b[18:15] == wr) hit = 1;
        if (b[24] && b[23:20] == wr) hit = 1;
        if (b[4]  && b[3:0]   == wr) hit = 1;
        if (b[32] && b[31:28] == wr) hit = 1;
      end
    end
    return hit;
  endfunction

  task automatic model_step();
    int s0;
    exp_pri = 0; exp_pair = 0; exp_st = 0;
    if (flush) begin
      mst = 0; mpv[0] = 0; mpv[1] = 0;
    end else if (mst > 1) begin
      mst--; exp_st = mst;
    end else begin
      s0 = v0 ? head_pen(d0) : 0;
      if (v0 && s0 > 0) begin
        mst = s0; exp_st = s0; mpv[0] = 0; mpv[1] = 0;
      end else if (v0) begin
        exp_pri  = 1;
        exp_pair = v1 && !conflicts(d0, d1) && !d1[35] && !d1[36] && !d0[36]
                   && head_pen(d1) == 0;
        mp[0] = d0; mpv[0] = 1; mp[1] = d1; mpv[1] = exp_pair; mst = 0;
      end else begin
        mst = 0; mpv[0] = 0; mpv[1] = 0;
      end
    end
    exp_pop = int'(exp_pri) + int'(exp_pair);
  endtask

  task automatic cycle(bit do_flush);
    @(negedge clk);
    nvec++;
    if (pri_issue !== exp_pri || pair_en !== exp_pair ||
        int'(pop_cnt) != exp_pop || int'(stall_cnt) != exp_st) begin
      nbad++;
      $display("FAIL %s: pri/pair/pop/stall got %0b/%0b/%0d/%0d expected %0b/%0b/%0d/%0d",
               prev_tag, pri_issue, pair_en, pop_cnt, stall_cnt,
               exp_pri, exp_pair, exp_pop, exp_st);
    end
    for (int k = 0; k < exp_pop; k++) if (prog.size() > 0) void'(prog.pop_front());
    v0 = prog.size() > 0;  d0 = v0 ? prog[0] : '0;
    v1 = prog.size() > 1;  d1 = v1 ? prog[1] : '0;
    flush = do_flush;
    prev_tag = cur_tag;
    model_step();
  endtask

  task automatic run_phase(string tag, int flush_at);
    int k = 0;
    int idle = 0;
    cur_tag = tag;
    while (idle < 3) begin
      cycle(k == flush_at);
      k++;
      if (prog.size() == 0 && mst == 0) idle++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    mpv[0] = 0; mpv[1] = 0;
    repeat (2) @(negedge clk);
    nvec++;
    if (pri_issue !== 1'b0 || pair_en !== 1'b0 || stall_cnt !== 2'd0) begin
      nbad++;
      $display("FAIL R2: reset outputs got %0b/%0b/%0d expected 0/0/0",
               pri_issue, pair_en, stall_cnt);
    end
    rst_n = 1'b1;
    run_phase("R2", -1);

    // R3 independent pairs
    prog.push_back(f_dst(1) | f_srca(2)); prog.push_back(f_dst(3) | f_srca(4));
    prog.push_back(f_dst(5) | f_srca(6)); prog.push_back(f_dst(7));
    run_phase("R3", -1);

    // R4 read-after-write, write-after-write, auto-update write
    prog.push_back(f_dst(0) | K_EARLY); prog.push_back(f_srca(0));
    prog.push_back(f_dst(2));           prog.push_back(f_dst(2) | f_srca(3));
    prog.push_back(f_base(9) | f_upd(9) | f_dst(1)); prog.push_back(f_srca(9) | f_dst(3));
    run_phase("R4", -1);

    // R5 floating point
    prog.push_back(f_dst(1)); prog.push_back(K_FP | f_dst(2));
    prog.push_back(K_FP);     prog.push_back(f_dst(4) | f_srca(5));
    run_phase("R5", -1);

    // R6 primary-only
    prog.push_back(K_PONLY | f_dst(1)); prog.push_back(f_dst(2));
    prog.push_back(f_dst(3));           prog.push_back(K_PONLY | f_dst(4));
    run_phase("R6", -1);

    // R7 invalid fields
    prog.push_back(f_dst(5) & ~(37'h10)); prog.push_back(f_srca(5) | f_dst(6));
    prog.push_back(f_dst(9));             prog.push_back(f_base(9) & ~(37'h80000));
    prog.push_back(f_dst(10) & ~(37'h10)); prog.push_back(f_base(10) | f_dst(1));
    run_phase("R7", -1);

    // R8 early results, fast address forms
    prog.push_back(f_dst(8) | K_EARLY | f_base(10)); prog.push_back(f_base(8) | f_dst(1));
    prog.push_back(f_dst(8) | K_EARLY); prog.push_back(f_idx(8, 0, 1) | f_dst(2));
    prog.push_back(f_dst(12) | K_EARLY); prog.push_back(f_idx(12, 2, 1) | f_dst(3));
    prog.push_back(f_base(11) | f_upd(11) | f_dst(2)); prog.push_back(f_base(11) | f_dst(3));
    run_phase("R8", -1);

    // R9 early results, slow index forms
    prog.push_back(f_dst(8) | K_EARLY); prog.push_back(f_idx(8, 1, 1) | f_dst(1));
    prog.push_back(f_dst(8) | K_EARLY); prog.push_back(f_idx(8, 0, 0) | f_dst(2));
    prog.push_back(f_dst(8) | K_EARLY); prog.push_back(f_idx(8, 3, 1) | f_dst(3));
    prog.push_back(f_upd(13) | f_base(13)); prog.push_back(f_idx(13, 2, 0) | f_dst(4));
    run_phase("R9", -1);

    // R10 address register loaded from memory
    prog.push_back(K_MEMLD | f_dst(9) | f_base(10)); prog.push_back(f_base(9) | f_dst(1));
    prog.push_back(K_MEMLD | f_dst(9) | f_base(10)); prog.push_back(f_idx(9, 1, 0) | f_dst(2));
    run_phase("R10", -1);

    // R11 ordinary producers
    prog.push_back(f_dst(10) | f_srca(1)); prog.push_back(f_base(10) | f_dst(2));
    prog.push_back(f_dst(10));             prog.push_back(f_srca(10) | f_dst(2));
    run_phase("R11", -1);

    // R12 stall against a paired group, slot 1 stall blocks pairing
    prog.push_back(f_dst(1) | f_srca(2)); prog.push_back(f_dst(12) | f_srca(3));
    prog.push_back(f_base(12) | f_dst(4));
    run_phase("R12", -1);
    prog.push_back(f_dst(13) | f_srca(0)); prog.push_back(f_dst(5) | f_srca(0));
    prog.push_back(f_dst(6));              prog.push_back(f_base(13) | f_dst(7));
    run_phase("R12", -1);

    // R13 flush in the middle of a stall
    prog.push_back(f_dst(10)); prog.push_back(f_base(10) | f_dst(1));
    prog.push_back(f_dst(2));
    run_phase("R13", 2);

    // R1 R3 randomised streams with the full descriptor layout
    for (int n = 0; n < 400; n++) prog.push_back(rand_desc());
    run_phase("R1 R3", -1);
    for (int n = 0; n < 200; n++) prog.push_back(rand_desc());
    run_phase("R13", 37);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule